// File: doc/BRIEF.md
# Loop Error Quantizer with Saturating Integrator

This block is the digital input stage of a buck converter's pulse-width control loop. Each update it takes a 16-tap thermometer snapshot from a time-based error digitizer. It counts the ones in that snapshot and turns the count into a 4-bit two's-complement error. It then adds that error, sign-extended, into a 10-bit integrator that clamps at its signed limits instead of wrapping. The upper eight bits of the integrator drive the duty-cycle generator.

The block also watches the size of each error. When the error magnitude falls below a programmable 3-bit threshold, the block lowers its own update rate to one update every four reference clocks. It does this with a clock-enable strobe and does not gate the clock. The same strobe paces the digitizer. The first update whose error reaches the threshold brings the block back to updating on every clock. The pulse-width switching rate is not affected, because the duty word simply holds its value between updates.

Top module: `errint_top`

## Requirements
- R1: While `rstN` is low, `errOut` = 0, `dutyWord` = 0 and `slowMode` = 0, and `updateEn` = 1.
- R2: On an update, `errOut` becomes (number of ones in `thermIn`) − 8, clamped to −8..+7. All sixteen ones give +7 (4'b0111). No ones give −8 (4'b1000). Exactly eight ones give 0.
- R3: The error depends only on how many bits of `thermIn` are set, not on where they are. A snapshot with a bubble is encoded by its ones count.
- R4: On an update, the 10-bit integrator becomes its previous value plus the sign-extended new error. `dutyWord` is integrator bits [9:2], read as two's complement. The integrator is zero after reset.
- R5: The integrator never wraps. A sum above +511 gives +511 (`dutyWord` = 8'h7F), and a sum below −512 gives −512 (`dutyWord` = 8'h80). Both limits hold while the error keeps pushing toward them.
- R6: On an update, `slowMode` becomes 1 if the absolute value of the new error is less than `ssThresh`, and 0 otherwise.
- R7: While `slowMode` is 1, `updateEn` is high on exactly one clock in four, measured from the previous update. On clocks where `updateEn` is low, `thermIn` is ignored and `errOut` and `dutyWord` hold.
- R8: With `ssThresh` = 0, `slowMode` never becomes 1.
- R9: While `slowMode` is 0, `updateEn` is high on every clock, so every clock is an update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| thermIn | input | 16 | Thermometer snapshot from the error digitizer |
| ssThresh | input | 3 | Steady-state magnitude threshold (1 is the usual setting) |
| errOut | output | 4 | Registered signed error from the latest update |
| dutyWord | output | 8 | Signed duty-cycle word, upper bits of the integrator |
| slowMode | output | 1 | High while the reduced update rate is active |
| updateEn | output | 1 | Update strobe; also the digitizer's sample enable |

## Verification
`updateEn` is decoded from state alone, so it is valid during the same cycle it applies to. `errOut`, `dutyWord` and `slowMode` change at the rising edge that ends a cycle in which `updateEn` was high. That edge uses the `thermIn` and `ssThresh` present during that cycle. The bench drives inputs on the falling edge and advances its reference model by one update decision. After the next rising edge it compares all four outputs on the following falling edge, so every comparison lands one register stage after its stimulus. In slow phases the bench keeps changing `thermIn` on the cycles between updates, and the model expects no response to those values.

// File: rtl/errint_pkg.sv
package errint_pkg;

  // Strobes passed from the rate control to the datapath
  typedef struct packed {
    logic update;   // load error register and integrator this clock
  } errintStrobe_t;

  // Clamp an integer into [lo, hi]
  function automatic int satInt(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/errint_therm_enc.sv
module errint_therm_enc #(
  parameter int THERM_W = 16,
  parameter int ERR_W   = 4
) (
  input  logic [THERM_W-1:0]      thermIn,
  output logic signed [ERR_W-1:0] errCode,
  output logic [ERR_W-1:0]        errMag
);
  localparam int CNT_W   = $clog2(THERM_W + 1);
  localparam int OFFSET  = THERM_W / 2;
  localparam int ERR_MAX = (1 << (ERR_W - 1)) - 1;
  localparam int ERR_MIN = -(1 << (ERR_W - 1));

  logic [CNT_W-1:0] onesCnt;
  int               diffVal;

  // Ones count: tolerant of bubbles anywhere in the snapshot
  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < THERM_W; i++) begin
      onesCnt = onesCnt + CNT_W'(thermIn[i]);
    end
  end

  // Centre on the mid tap and clamp to the signed error range
  always_comb begin
    diffVal = errint_pkg::satInt(int'(onesCnt) - OFFSET, ERR_MIN, ERR_MAX);
    errCode = ERR_W'(diffVal);
    errMag  = (diffVal < 0) ? ERR_W'(-diffVal) : ERR_W'(diffVal);
  end

endmodule

// File: rtl/errint_datapath.sv
module errint_datapath
  import errint_pkg::*;
#(
  parameter int THERM_W = 16,
  parameter int ERR_W   = 4,
  parameter int ACC_W   = 10,
  parameter int DUTY_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  errintStrobe_t       strobe,
  input  logic [THERM_W-1:0]  thermIn,
  output logic [ERR_W-1:0]    errMag,
  output logic [ERR_W-1:0]    errOut,
  output logic [DUTY_W-1:0]   dutyWord
);
  localparam int EXT_W = ACC_W + 1 - ERR_W;
  localparam logic [ACC_W-1:0] ACC_TOP = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_BOT = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ERR_W-1:0] errCode;
  logic [ERR_W-1:0]        errReg;
  logic [ACC_W-1:0]        accReg;
  logic [ACC_W:0]          sumWide;
  logic [ACC_W-1:0]        accNext;
  logic                    ovf;

  errint_therm_enc #(
    .THERM_W (THERM_W),
    .ERR_W   (ERR_W)
  ) u_enc (
    .thermIn (thermIn),
    .errCode (errCode),
    .errMag  (errMag)
  );

  // One guard bit: sign disagreement between the top two bits flags overflow
  always_comb begin
    sumWide = {accReg[ACC_W-1], accReg} + {{EXT_W{errCode[ERR_W-1]}}, errCode};
    ovf     = sumWide[ACC_W] ^ sumWide[ACC_W-1];
    if (ovf) accNext = sumWide[ACC_W] ? ACC_BOT : ACC_TOP;
    else     accNext = sumWide[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errReg <= '0;
      accReg <= '0;
    end else if (strobe.update) begin
      errReg <= errCode;
      accReg <= accNext;
    end
  end

  // Duty word is the top slice of the integrator
  generate
    if (DUTY_W <= ACC_W) begin : g_slice
      assign dutyWord = accReg[ACC_W-1 -: DUTY_W];
    end else begin : g_pad
      assign dutyWord = {accReg, {(DUTY_W-ACC_W){1'b0}}};
    end
  endgenerate

  assign errOut = errReg;

endmodule

// File: rtl/errint_control.sv
module errint_control
  import errint_pkg::*;
#(
  parameter int ERR_W    = 4,
  parameter int THR_W    = 3,
  parameter int SLOW_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ERR_W-1:0] errMag,
  input  logic [THR_W-1:0] ssThresh,
  output errintStrobe_t    strobe,
  output logic             slowMode,
  output logic             updateEn
);
  localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic             slowReg;
  logic             quietErr;

  assign quietErr   = int'(errMag) < int'(ssThresh);
  assign updateEn   = !slowReg || (divCnt == '0);
  assign strobe.update = updateEn;
  assign slowMode   = slowReg;

  // Phase counter restarts at 1 after each update, so the next slow
  // update lands SLOW_DIV clocks later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      slowReg <= 1'b0;
    end else if (updateEn) begin
      divCnt  <= DIV_W'(1);
      slowReg <= quietErr;
    end else begin
      divCnt  <= (divCnt == DIV_LAST) ? '0 : divCnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/errint_top.sv
module errint_top
  import errint_pkg::*;
#(
  parameter int THERM_W  = 16,
  parameter int ERR_W    = 4,
  parameter int ACC_W    = 10,
  parameter int DUTY_W   = 8,
  parameter int THR_W    = 3,
  parameter int SLOW_DIV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [THERM_W-1:0] thermIn,
  input  logic [THR_W-1:0]   ssThresh,
  output logic [ERR_W-1:0]   errOut,
  output logic [DUTY_W-1:0]  dutyWord,
  output logic               slowMode,
  output logic               updateEn
);
  errintStrobe_t    strobe;
  logic [ERR_W-1:0] errMag;

  errint_control #(
    .ERR_W    (ERR_W),
    .THR_W    (THR_W),
    .SLOW_DIV (SLOW_DIV)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .errMag   (errMag),
    .ssThresh (ssThresh),
    .strobe   (strobe),
    .slowMode (slowMode),
    .updateEn (updateEn)
  );

  errint_datapath #(
    .THERM_W (THERM_W),
    .ERR_W   (ERR_W),
    .ACC_W   (ACC_W),
    .DUTY_W  (DUTY_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .thermIn  (thermIn),
    .errMag   (errMag),
    .errOut   (errOut),
    .dutyWord (dutyWord)
  );

endmodule

// File: rtl/errint_checker.sv
module errint_checker #(
  parameter int THERM_W = 16,
  parameter int ERR_W   = 4,
  parameter int DUTY_W  = 8,
  parameter int THR_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [THERM_W-1:0] thermIn,
  input logic [THR_W-1:0]   ssThresh,
  input logic [ERR_W-1:0]   errOut,
  input logic [DUTY_W-1:0]  dutyWord,
  input logic               slowMode,
  input logic               updateEn
);
  localparam int OFFSET = THERM_W / 2;
  localparam logic [ERR_W-1:0]  ERR_TOP  = {1'b0, {(ERR_W-1){1'b1}}};
  localparam logic [ERR_W-1:0]  ERR_BOT  = {1'b1, {(ERR_W-1){1'b0}}};
  localparam logic [DUTY_W-1:0] DUTY_TOP = {1'b0, {(DUTY_W-1){1'b1}}};
  localparam logic [DUTY_W-1:0] DUTY_BOT = {1'b1, {(DUTY_W-1){1'b0}}};

  p_full_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && $countones(thermIn) == THERM_W) |=> errOut == ERR_TOP);

  p_empty_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && $countones(thermIn) == 0) |=> errOut == ERR_BOT);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && dutyWord == DUTY_TOP && $countones(thermIn) >= OFFSET) |=> dutyWord == DUTY_TOP);

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && dutyWord == DUTY_BOT && $countones(thermIn) <= OFFSET) |=> dutyWord == DUTY_BOT);

  p_enter_slow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && $countones(thermIn) == OFFSET && ssThresh != '0) |=> slowMode);

  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rstN)
    !updateEn |=> ($stable(errOut) && $stable(dutyWord)));

  p_slow_spacing_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slowMode && updateEn) |=> (!slowMode || !updateEn));

  p_zero_thresh_r8: assert property (@(posedge clk) disable iff (!rstN)
    (updateEn && ssThresh == '0) |=> !slowMode);

  p_fast_rate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !slowMode |-> updateEn);

endmodule

bind errint_top errint_checker #(
  .THERM_W (THERM_W),
  .ERR_W   (ERR_W),
  .DUTY_W  (DUTY_W),
  .THR_W   (THR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .thermIn  (thermIn),
  .ssThresh (ssThresh),
  .errOut   (errOut),
  .dutyWord (dutyWord),
  .slowMode (slowMode),
  .updateEn (updateEn)
);

// File: tb/errint_top_tb.sv
module errint_top_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] thermIn;
  logic [2:0]  ssThresh;
  logic [3:0]  errOut;
  logic [7:0]  dutyWord;
  logic        slowMode;
  logic        updateEn;

  always #10 clk = ~clk;

  errint_top u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .thermIn  (thermIn),
    .ssThresh (ssThresh),
    .errOut   (errOut),
    .dutyWord (dutyWord),
    .slowMode (slowMode),
    .updateEn (updateEn)
  );

  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 1'b0;
  string curTag = "R1";

  // Behavioural reference state
  int mAcc = 0;
  int mErr = 0;
  int mSlow = 0;
  int mDiv = 0;
  int mUpdCount = 0;

  function automatic logic [15:0] therm(input int c);
    logic [31:0] w;
    w = (32'd1 << c) - 32'd1;
    return w[15:0];
  endfunction

  function automatic int encErr(input logic [15:0] v);
    int e;
    e = $countones(v) - 8;
    if (e > 7) e = 7;
    return e;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", curTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("errOut",   int'($signed(errOut)),   mErr);
    chk("dutyWord", int'($signed(dutyWord)), mAcc >>> 2);
    chk("slowMode", int'(slowMode),          mSlow);
    chk("updateEn", int'(updateEn),          (mSlow == 0 || mDiv == 0) ? 1 : 0);
  endtask

  // Called just after a falling edge: drive, advance model, compare one edge later
  task automatic step(input logic [15:0] th, input logic [2:0] thr);
    int e;
    int mag;
    thermIn  = th;
    ssThresh = thr;
    if (mSlow == 0 || mDiv == 0) begin
      e    = encErr(th);
      mErr = e;
      mAcc = mAcc + e;
      if (mAcc > 511)  mAcc = 511;
      if (mAcc < -512) mAcc = -512;
      mag  = (e < 0) ? -e : e;
      mSlow = (mag < int'(thr)) ? 1 : 0;
      mDiv = 1;
      mUpdCount++;
    end else begin
      mDiv = (mDiv + 1) % 4;
    end
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    int updStart;
    rstN     = 1'b0;
    thermIn  = '0;
    ssThresh = '0;
    repeat (3) @(negedge clk);
    curTag = "R1";
    compareAll();
    rstN = 1'b1;

    // R2: every ones count from 0 to 16, full rate
    curTag = "R2";
    for (int c = 0; c <= 16; c++) step(therm(c), 3'd0);
    step(16'h0000, 3'd0);
    chk("errOut all-zero snapshot", int'($signed(errOut)), -8);
    step(16'hFFFF, 3'd0);
    chk("errOut all-ones snapshot", int'($signed(errOut)), 7);

    // R8: zero threshold never enters slow mode even with zero error
    curTag = "R8";
    for (int i = 0; i < 6; i++) step(therm(8), 3'd0);
    chk("slowMode with zero threshold", int'(slowMode), 0);

    // R3: bubbled snapshots
    curTag = "R3";
    step(16'hAAAA, 3'd0);
    chk("errOut for alternating bits", int'($signed(errOut)), 0);
    step(16'h00F1, 3'd0);
    chk("errOut for five scattered ones", int'($signed(errOut)), -3);
    for (int i = 0; i < 40; i++) step(16'($urandom), 3'd0);

    // R4: small errors integrate
    curTag = "R4";
    for (int i = 0; i < 30; i++) step(therm(6 + int'($urandom % 5)), 3'd0);

    // R5: drive into both limits and keep pushing
    curTag = "R5";
    for (int i = 0; i < 90; i++) step(16'hFFFF, 3'd0);
    chk("dutyWord at upper clamp", int'($signed(dutyWord)), 127);
    for (int i = 0; i < 160; i++) step(16'h0000, 3'd0);
    chk("dutyWord at lower clamp", int'($signed(dutyWord)), -128);

    // R6: enter slow mode with zero error and threshold 1
    curTag = "R6";
    step(therm(8), 3'd1);
    chk("slowMode after zero error", int'(slowMode), 1);

    // R7: one update in four; inputs between updates ignored
    curTag = "R7";
    updStart = mUpdCount;
    for (int i = 0; i < 40; i++) step(therm(7 + int'($urandom % 3)), 3'd2);
    chk("updates in 40 slow clocks", mUpdCount - updStart, 10);

    // R9: large error returns to full rate
    curTag = "R9";
    for (int i = 0; i < 12; i++) step(therm(14), 3'd2);
    chk("slowMode after large error", int'(slowMode), 0);
    chk("updateEn at full rate", int'(updateEn), 1);

    // R6: mixed thresholds and snapshots
    curTag = "R6";
    for (int i = 0; i < 400; i++)
      step(($urandom % 2 == 0) ? therm(int'($urandom % 17)) : 16'($urandom),
           3'($urandom));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL %s watchdog: actual timeout expected completion", curTag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule